// File: doc/BRIEF.md
# Bus-Attached Scratchpad Memory Controller

This block is a small on-chip word memory that sits on a register-style bus. Every bus transaction carries an offset, a mode (read, write or execute) and a 64-bit write word. The response comes back combinationally in the same cycle as the request: a 64-bit read word and a 2-bit return code. Any write takes effect at the clock edge that closes the transaction.

Offsets below a control base reach the word array directly. Offsets at or above the base open a small register bank. The bank holds a mode register, a word pointer, a read-only status word, a coded soft-reset register and a free-form repair register. It also holds three windows that reach the array through the pointer:

- a plain window, which leaves the pointer alone;
- a stepping-up window;
- a stepping-down window.

Two mode-register bits choose whether each stepping window moves the pointer before or after the access. Errors set sticky flags in the status word. Only the soft-reset code or the hardware reset clears them.

Top module: `scratch_store`

## Requirements
- R1: A legal read or write at an offset below DEPTH reaches array word `offset` directly. It returns code 0 (success). Direct read data is the stored word.
- R2: Mode 2 (execute) behaves exactly like mode 0 (read) on direct accesses, register reads and window reads. Mode 1 is write.
- R3: Stepping-up window (base+6): with mode bit 0 set, the access uses pointer+1. Otherwise it uses the pointer. In both cases the pointer ends one higher.
- R4: Stepping-down window (base+7): with mode bit 1 clear, the access uses pointer-1. Otherwise it uses the pointer. In both cases the pointer ends one lower.
- R5: The pointer moves even when the window access fails. It wraps modulo 2^PTR_W. The plain window (base+5) never moves it.
- R6: A direct access at an offset in [DEPTH, CTRL_BASE) leaves the array untouched and returns code 1. It sets status bit 0. It also sets bit 1 for a write, or bit 2 for a read or execute.
- R7: A window access whose effective pointer is not below DEPTH leaves the array untouched, returns code 2 and sets status bit 3.
- R8: Register writes keep only the defined bits: mode register bits [1:0] at base+0, pointer bits [PTR_W-1:0] at base+1, reset field bits [15:0] at base+3. The repair register at base+4 keeps the whole word.
- R9: Writing 16'h5A3C into the reset field clears the mode, pointer, status flags, reset and repair registers. Status (base+2) then reads 16'h0010, with the idle state code 1 in bits [7:4]. The same value is the hardware reset state.
- R10: An undefined register offset (base+8 and above), a write to the status register, or mode 3 returns code 3. It changes no state, and its read data is zero.
- R11: Status flag bits [3:0] are sticky. Once set, they stay set until a coded soft reset or a hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transaction present this cycle |
| reqOffset | input | OFF_W | Transaction offset |
| reqMode | input | 2 | 0 read, 1 write, 2 execute, 3 illegal |
| reqWdata | input | DATA_W | Write word |
| rspData | output | DATA_W | Read word, same cycle; zero when nothing is read |
| rspCode | output | 2 | 0 success, 1 direct address error, 2 window address error, 3 rejected |

## Verification
A wrong pointer shows at the first window access after the fault. It returns the wrong word, or a code 2 where success was due. A readback of base+1 shows it at once. A stuck or missing status flag shows on the next status read. A mistaken array write shows only when that word is read again.

For these reasons the sweep reads the pointer back after every window access, and reads each written word back directly.

// File: rtl/scratch_store_pkg.sv
package scratch_store_pkg;
  localparam logic [1:0] MODE_RD = 2'd0;
  localparam logic [1:0] MODE_WR = 2'd1;
  localparam logic [1:0] MODE_EX = 2'd2;

  localparam logic [1:0] RSP_OK   = 2'd0;
  localparam logic [1:0] RSP_ADDR = 2'd1;
  localparam logic [1:0] RSP_PKT  = 2'd2;
  localparam logic [1:0] RSP_REJ  = 2'd3;

  // register bank index, relative to the control base
  localparam int REG_MODE  = 0;
  localparam int REG_PTR   = 1;
  localparam int REG_STAT  = 2;
  localparam int REG_RST   = 3;
  localparam int REG_REP   = 4;
  localparam int WIN_PLAIN = 5;
  localparam int WIN_UP    = 6;
  localparam int WIN_DOWN  = 7;
  localparam int REG_COUNT = 8;

  localparam int          RST_W      = 16;
  localparam logic [15:0] RESET_CODE = 16'h5A3C;
  localparam logic [3:0]  STATE_IDLE = 4'h1;

  // status flag bit positions
  localparam int FLG_ADDR  = 0;
  localparam int FLG_WRBAD = 1;
  localparam int FLG_RDBAD = 2;
  localparam int FLG_ARRAY = 3;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MEM, SEL_MODE, SEL_PTR, SEL_STAT, SEL_RST, SEL_REP
  } rdsel_e;

  typedef struct packed {
    logic       memWe;
    logic       modeWe;
    logic       ptrWe;
    logic       ptrUp;
    logic       ptrDown;
    logic       rstWe;
    logic       repWe;
    logic       softRst;
    logic [3:0] flagSet;
    rdsel_e     rdSel;
  } strobe_t;
endpackage

// File: rtl/scratch_store_ctrl.sv
module scratch_store_ctrl
  import scratch_store_pkg::*;
#(
  parameter int DEPTH     = 40,
  parameter int CTRL_BASE = 64,
  parameter int OFF_W     = 8,
  parameter int PTR_W     = $clog2(CTRL_BASE)
) (
  input  logic             reqValid,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [1:0]       reqMode,
  input  logic [RST_W-1:0] codeIn,
  input  logic [PTR_W-1:0] ptrQ,
  input  logic             preUp,
  input  logic             postDown,
  output strobe_t          strb,
  output logic [PTR_W-1:0] memIdx,
  output logic [1:0]       rspCode
);
  localparam logic [PTR_W:0]   DEPTH_P  = (PTR_W+1)'(DEPTH);
  localparam logic [OFF_W-1:0] DEPTH_O  = OFF_W'(DEPTH);
  localparam logic [OFF_W-1:0] BASE_O   = OFF_W'(CTRL_BASE);

  logic             isRead, isWrite, isDirect;
  logic [OFF_W-1:0] regIdx;
  logic [PTR_W-1:0] effPtr;
  logic             effOk;

  assign isRead   = (reqMode == MODE_RD) || (reqMode == MODE_EX);
  assign isWrite  = (reqMode == MODE_WR);
  assign isDirect = reqOffset < BASE_O;
  assign regIdx   = reqOffset - BASE_O;

  always_comb begin
    effPtr = ptrQ;
    if (regIdx == OFF_W'(WIN_UP) && preUp)
      effPtr = ptrQ + 1'b1;
    else if (regIdx == OFF_W'(WIN_DOWN) && !postDown)
      effPtr = ptrQ - 1'b1;
  end
  assign effOk = {1'b0, effPtr} < DEPTH_P;

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    memIdx     = '0;
    rspCode    = RSP_OK;
    if (reqValid) begin
      if (!(isRead || isWrite)) begin
        rspCode = RSP_REJ;
      end else if (isDirect) begin
        if (reqOffset < DEPTH_O) begin
          memIdx     = reqOffset[PTR_W-1:0];
          strb.memWe = isWrite;
          strb.rdSel = isRead ? SEL_MEM : SEL_NONE;
        end else begin
          strb.flagSet[FLG_ADDR]  = 1'b1;
          strb.flagSet[FLG_WRBAD] = isWrite;
          strb.flagSet[FLG_RDBAD] = isRead;
          rspCode = RSP_ADDR;
        end
      end else begin
        case (regIdx)
          OFF_W'(REG_MODE): if (isWrite) strb.modeWe = 1'b1; else strb.rdSel = SEL_MODE;
          OFF_W'(REG_PTR):  if (isWrite) strb.ptrWe  = 1'b1; else strb.rdSel = SEL_PTR;
          OFF_W'(REG_STAT): if (isWrite) rspCode = RSP_REJ; else strb.rdSel = SEL_STAT;
          OFF_W'(REG_RST): begin
            if (isWrite) begin
              strb.rstWe   = 1'b1;
              strb.softRst = (codeIn == RESET_CODE);
            end else strb.rdSel = SEL_RST;
          end
          OFF_W'(REG_REP):  if (isWrite) strb.repWe = 1'b1; else strb.rdSel = SEL_REP;
          OFF_W'(WIN_PLAIN), OFF_W'(WIN_UP), OFF_W'(WIN_DOWN): begin
            strb.ptrUp   = (regIdx == OFF_W'(WIN_UP));
            strb.ptrDown = (regIdx == OFF_W'(WIN_DOWN));
            if (effOk) begin
              memIdx     = effPtr;
              strb.memWe = isWrite;
              strb.rdSel = isRead ? SEL_MEM : SEL_NONE;
            end else begin
              strb.flagSet[FLG_ARRAY] = 1'b1;
              rspCode = RSP_PKT;
            end
          end
          default: rspCode = RSP_REJ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scratch_store_dp.sv
module scratch_store_dp
  import scratch_store_pkg::*;
#(
  parameter int DEPTH  = 40,
  parameter int DATA_W = 64,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [PTR_W-1:0]  memIdx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PTR_W-1:0]  ptrQ,
  output logic              preUp,
  output logic              postDown
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [1:0]        modeQ;
  logic [3:0]        flagsQ;
  logic [RST_W-1:0]  rstQ;
  logic [DATA_W-1:0] repQ;

  assign preUp    = modeQ[0];
  assign postDown = modeQ[1];

  always_ff @(posedge clk) begin
    if (!rstN || strb.softRst) begin
      modeQ  <= '0;
      ptrQ   <= '0;
      flagsQ <= '0;
      rstQ   <= '0;
      repQ   <= '0;
    end else begin
      if (strb.modeWe) modeQ <= wdata[1:0];
      if (strb.ptrWe)        ptrQ <= wdata[PTR_W-1:0];
      else if (strb.ptrUp)   ptrQ <= ptrQ + 1'b1;
      else if (strb.ptrDown) ptrQ <= ptrQ - 1'b1;
      if (strb.rstWe) rstQ <= wdata[RST_W-1:0];
      if (strb.repWe) repQ <= wdata;
      flagsQ <= flagsQ | strb.flagSet;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.memWe) mem[memIdx] <= wdata;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_MEM:  rdata = mem[memIdx];
      SEL_MODE: rdata = DATA_W'(modeQ);
      SEL_PTR:  rdata = DATA_W'(ptrQ);
      SEL_STAT: rdata = DATA_W'({STATE_IDLE, flagsQ});
      SEL_RST:  rdata = DATA_W'(rstQ);
      SEL_REP:  rdata = repQ;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/scratch_store.sv
module scratch_store
  import scratch_store_pkg::*;
#(
  parameter int DEPTH     = 40,
  parameter int DATA_W    = 64,
  parameter int CTRL_BASE = 64,
  parameter int OFF_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [1:0]        reqMode,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspData,
  output logic [1:0]        rspCode
);
  localparam int PTR_W = $clog2(CTRL_BASE);

  strobe_t          strb;
  logic [PTR_W-1:0] memIdx;
  logic [PTR_W-1:0] ptrNow;
  logic             preUp, postDown;

  scratch_store_ctrl #(
    .DEPTH(DEPTH), .CTRL_BASE(CTRL_BASE), .OFF_W(OFF_W), .PTR_W(PTR_W)
  ) u_ctrl (
    .reqValid(reqValid), .reqOffset(reqOffset), .reqMode(reqMode),
    .codeIn(reqWdata[RST_W-1:0]), .ptrQ(ptrNow), .preUp(preUp),
    .postDown(postDown), .strb(strb), .memIdx(memIdx), .rspCode(rspCode)
  );

  scratch_store_dp #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memIdx(memIdx), .wdata(reqWdata),
    .rdata(rspData), .ptrQ(ptrNow), .preUp(preUp), .postDown(postDown)
  );
endmodule

// File: rtl/scratch_store_chk.sv
module scratch_store_chk
  import scratch_store_pkg::*;
#(
  parameter int DEPTH     = 40,
  parameter int DATA_W    = 64,
  parameter int CTRL_BASE = 64,
  parameter int OFF_W     = 8,
  parameter int PTR_W     = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [OFF_W-1:0]  reqOffset,
  input logic [1:0]        reqMode,
  input logic [DATA_W-1:0] reqWdata,
  input logic [1:0]        rspCode,
  input logic [PTR_W-1:0]  ptrNow,
  input logic [3:0]        flagsNow
);
  localparam logic [OFF_W-1:0] BASE_O = OFF_W'(CTRL_BASE);
  logic legal, codeHit;
  assign legal   = reqValid && (reqMode != 2'd3);
  assign codeHit = legal && reqMode == MODE_WR && reqOffset == BASE_O + OFF_W'(REG_RST)
                   && reqWdata[RST_W-1:0] == RESET_CODE;

  AST_DIRECT_OOB: assert property (@(posedge clk) disable iff (!rstN)
    legal && reqOffset < BASE_O && reqOffset >= OFF_W'(DEPTH) |-> rspCode == RSP_ADDR); // R6
  AST_ILLEGAL_MODE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqMode == 2'd3 |-> rspCode == RSP_REJ); // R10
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    legal && reqOffset == BASE_O + OFF_W'(WIN_UP) |=> ptrNow == PTR_W'($past(ptrNow) + 1'b1)); // R3
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    legal && reqOffset == BASE_O + OFF_W'(WIN_DOWN) |=> ptrNow == PTR_W'($past(ptrNow) - 1'b1)); // R4
  AST_PLAIN_OOB: assert property (@(posedge clk) disable iff (!rstN)
    legal && reqOffset == BASE_O + OFF_W'(WIN_PLAIN) && {1'b0, ptrNow} >= (PTR_W+1)'(DEPTH)
    |-> rspCode == RSP_PKT); // R7
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flagsNow) & ~flagsNow) != 4'd0 |-> $past(codeHit)); // R11
endmodule

bind scratch_store scratch_store_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .CTRL_BASE(CTRL_BASE), .OFF_W(OFF_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset),
  .reqMode(reqMode), .reqWdata(reqWdata), .rspCode(rspCode),
  .ptrNow(ptrNow), .flagsNow(u_dp.flagsQ)
);

// File: tb/sim_scratch_store.sv
`timescale 1ns/1ps
module sim_scratch_store;
  localparam int DEPTH = 40;
  localparam int BASE  = 64;

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic [7:0]  reqOffset = 0;
  logic [1:0]  reqMode = 0;
  logic [63:0] reqWdata = 0;
  logic [63:0] rspData;
  logic [1:0]  rspCode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  logic [63:0] mirror [64];

  always #10 clk = ~clk;

  scratch_store u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset),
    .reqMode(reqMode), .reqWdata(reqWdata), .rspData(rspData), .rspCode(rspCode)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [7:0] off, input logic [1:0] md, input logic [63:0] wd,
                     output logic [63:0] rd, output logic [1:0] cd);
    @(negedge clk);
    reqValid = 1; reqOffset = off; reqMode = md; reqWdata = wd;
    #5;
    rd = rspData; cd = rspCode;
    @(posedge clk);
    #1 reqValid = 0;
  endtask

  function automatic logic [63:0] pat(input int i);
    return 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] rd;
    logic [1:0]  cd;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // hardware reset state
    txn(8'(BASE+2), 2'd0, 0, rd, cd); check("R9 reset status", rd, 64'h10);
    txn(8'(BASE+0), 2'd0, 0, rd, cd); check("R9 reset mode reg", rd, 0);
    txn(8'(BASE+1), 2'd0, 0, rd, cd); check("R9 reset pointer", rd, 0);

    // direct fill and readback
    for (int i = 0; i < DEPTH; i++) begin
      txn(8'(i), 2'd1, pat(i), rd, cd); check("R1 direct write code", 64'(cd), 0);
      mirror[i] = pat(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      txn(8'(i), (i % 2) ? 2'd2 : 2'd0, 0, rd, cd);
      check((i % 2) ? "R2 execute direct data" : "R1 direct read data", rd, mirror[i]);
      check("R1 direct read code", 64'(cd), 0);
    end

    // direct out of range
    for (int i = DEPTH; i < BASE; i++) begin
      txn(8'(i), 2'd1, 64'hDEAD, rd, cd); check("R6 direct write oob code", 64'(cd), 1);
      txn(8'(i), 2'd2, 0, rd, cd);        check("R6 direct exec oob code", 64'(cd), 1);
    end
    txn(8'(BASE+2), 2'd2, 0, rd, cd); check("R6 status flags / R2 exec reg", rd, 64'h17);

    // reset register: non-code value masked and stored, flags kept
    txn(8'(BASE+3), 2'd1, 64'hFFFF_FFFF_FFFF_1234, rd, cd);
    txn(8'(BASE+3), 2'd0, 0, rd, cd); check("R8 reset field mask", rd, 64'h1234);
    txn(8'(BASE+2), 2'd0, 0, rd, cd); check("R11 flags held", rd, 64'h17);
    txn(8'(BASE+0), 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, rd, cd);
    txn(8'(BASE+0), 2'd0, 0, rd, cd); check("R8 mode reg mask", rd, 64'h3);
    txn(8'(BASE+1), 2'd1, 64'hFFFF_FFFF_FFFF_FFC5, rd, cd);
    txn(8'(BASE+1), 2'd0, 0, rd, cd); check("R8 pointer mask", rd, 64'h05);
    txn(8'(BASE+4), 2'd1, 64'hA1B2_C3D4_E5F6_0718, rd, cd);
    txn(8'(BASE+4), 2'd2, 0, rd, cd); check("R8 repair full word", rd, 64'hA1B2_C3D4_E5F6_0718);

    // coded soft reset
    txn(8'(BASE+3), 2'd1, 64'hFFFF_0000_0000_5A3C, rd, cd); check("R9 code write", 64'(cd), 0);
    txn(8'(BASE+2), 2'd0, 0, rd, cd); check("R9 status after code", rd, 64'h10);
    txn(8'(BASE+0), 2'd0, 0, rd, cd); check("R9 mode after code", rd, 0);
    txn(8'(BASE+1), 2'd0, 0, rd, cd); check("R9 pointer after code", rd, 0);
    txn(8'(BASE+3), 2'd0, 0, rd, cd); check("R9 reset reg after code", rd, 0);
    txn(8'(BASE+4), 2'd0, 0, rd, cd); check("R9 repair after code", rd, 0);
    txn(8'(5), 2'd0, 0, rd, cd); check("R9 array kept", rd, mirror[5]);

    // window sweep
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 7; k++) begin
        for (int w = 0; w < 3; w++) begin
          for (int wr = 0; wr < 2; wr++) begin
            int p, eff, np;
            bit ok;
            logic [63:0] wv;
            string tg;
            case (k)
              0: p = 0; 1: p = 1; 2: p = 20; 3: p = 38; 4: p = 39; 5: p = 40; default: p = 63;
            endcase
            tg  = (w == 0) ? "R5 plain" : (w == 1) ? "R3 up" : "R4 down";
            eff = (w == 1 && m[0]) ? p + 1 : (w == 2 && !m[1]) ? p - 1 : p;
            eff = (eff + 64) % 64;
            np  = (w == 1) ? p + 1 : (w == 2) ? p - 1 : p;
            np  = (np + 64) % 64;
            ok  = eff < DEPTH;
            wv  = 64'h5500_0000_0000_0000 | 64'(m * 1000 + k * 100 + w * 10 + wr);
            txn(8'(BASE+0), 2'd1, 64'(m), rd, cd);
            txn(8'(BASE+1), 2'd1, 64'(p), rd, cd);
            if (wr == 0) begin
              txn(8'(BASE+5+w), (k % 2) ? 2'd2 : 2'd0, 0, rd, cd);
              check({tg, " read data"}, rd, ok ? mirror[eff] : 64'h0);
            end else begin
              txn(8'(BASE+5+w), 2'd1, wv, rd, cd);
              if (ok) mirror[eff] = wv;
            end
            check(ok ? {tg, " code"} : "R7 window oob code", 64'(cd), ok ? 0 : 2);
            txn(8'(BASE+1), 2'd0, 0, rd, cd);
            check({tg, " R5 pointer after"}, rd, 64'(np));
            if (wr == 1 && ok) begin
              txn(8'(eff), 2'd0, 0, rd, cd);
              check({tg, " written word"}, rd, wv);
            end
          end
        end
      end
    end
    txn(8'(BASE+2), 2'd0, 0, rd, cd); check("R7 status array flag", rd, 64'h18);

    // rejections
    for (int o = BASE + 8; o < 256; o += 7) begin
      txn(8'(o), 2'd0, 0, rd, cd);
      check("R10 undefined read code", 64'(cd), 3); check("R10 undefined read data", rd, 0);
      txn(8'(o), 2'd1, 64'h1, rd, cd); check("R10 undefined write code", 64'(cd), 3);
    end
    txn(8'(BASE+2), 2'd1, 64'h0, rd, cd); check("R10 status write code", 64'(cd), 3);
    txn(8'(BASE+2), 2'd0, 0, rd, cd); check("R10 status unchanged", rd, 64'h18);
    txn(8'(7), 2'd3, 64'hBAD, rd, cd); check("R10 illegal mode code", 64'(cd), 3);
    check("R10 illegal mode data", rd, 0);
    txn(8'(7), 2'd0, 0, rd, cd); check("R10 array unchanged", rd, mirror[7]);
    txn(8'(BASE+1), 2'd1, 64'd9, rd, cd);
    txn(8'(BASE+1), 2'd3, 64'd30, rd, cd);
    txn(8'(BASE+6), 2'd3, 64'd0, rd, cd);
    txn(8'(BASE+1), 2'd0, 0, rd, cd); check("R10 pointer unchanged", rd, 64'd9);
    txn(8'(BASE+3), 2'd3, 64'h5A3C, rd, cd);
    txn(8'(BASE+2), 2'd0, 0, rd, cd); check("R11 flags survive rejected code", rd, 64'h18);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule